// File: doc/BRIEF.md
# Four-way page translation buffer with tree pseudo-LRU

This block caches translations from 4-Kbyte linear pages to physical page frames. It holds 64 entries, arranged as 16 sets of four ways. A request on the lookup port returns, one cycle later, either a hit with the full physical address or a miss. The page walker, or any other agent that has resolved a translation, installs it through the fill port. A flush input discards every cached translation in a single cycle.

Each set has three tree pseudo-LRU bits that pick the way a fill replaces once the set is full. Every entry stores one parity bit over its tag and a second parity bit over its frame number. Both bits are computed by whoever fills the entry. A lookup that matches an entry whose stored fields disagree with either parity bit is answered as a miss and raises a parity-error flag. The requester then retranslates instead of using corrupted data.

Top module: `xlat_top`

## Requirements
- R1: A lookup request (`lkp_vld_i` high at a clock edge) produces exactly one response. `rsp_vld_o` is high in the following cycle and low in every cycle that does not follow a request. On a hit, `rsp_hit_o` is 1 and `rsp_pa_o` equals the stored 20-bit frame number in bits [31:12] joined with linear address bits [11:0] in bits [11:0].
- R2: The set is selected by linear address bits [15:12] and the tag is bits [31:16]. An entry is found only by an address with the same tag in the same set.
- R3: A lookup that finds no valid matching entry returns `rsp_hit_o` = 0, `rsp_pa_o` = 0 and `rsp_par_err_o` = 0.
- R4: A fill into a set that has an invalid way writes the lowest-numbered invalid way. Four fills with distinct tags into one empty set therefore all remain present.
- R5: A fill into a full set replaces the way named by that set's three bits. Bit 0 = 0 selects the pair {0,1} and bit 0 = 1 selects the pair {2,3}. Within the pair, bit 1 picks way 1 over way 0 when set, and bit 2 picks way 3 over way 2 when set. All bits are 0 after reset.
- R6: Each lookup hit and each fill updates its set's bits to point away from the way it used. Bit 0 is set to 1 when the way is 0 or 1 and to 0 when it is 2 or 3. The bit of the used pair is set to the opposite of the low bit of the way number. When a fill and a lookup hit touch the same set in one cycle, the fill's update is the one kept.
- R7: `fill_tag_par_i` must equal the XOR of address bits [31:16], and `fill_pfn_par_i` the XOR of the frame number (even parity). A lookup that matches a valid entry with either stored parity bit wrong returns `rsp_hit_o` = 0, `rsp_pa_o` = 0 and `rsp_par_err_o` = 1.
- R8: `flush_i` invalidates every entry at the next clock edge. A fill presented in the same cycle as a flush is discarded.
- R9: A lookup in the same cycle as a fill or a flush sees the contents from before that cycle's update.
- R10: After reset no entry is valid and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_vld_i | input | 1 | Lookup request strobe |
| lkp_va_i | input | 32 | Linear address to translate |
| fill_vld_i | input | 1 | Install strobe |
| fill_va_i | input | 32 | Linear address of the page being installed |
| fill_pfn_i | input | 20 | Physical frame number to install |
| fill_tag_par_i | input | 1 | Even parity over fill_va_i[31:16] |
| fill_pfn_par_i | input | 1 | Even parity over fill_pfn_i |
| flush_i | input | 1 | Invalidate all entries |
| rsp_vld_o | output | 1 | Response strobe, one cycle after a request |
| rsp_hit_o | output | 1 | Translation found and intact |
| rsp_pa_o | output | 32 | Physical address on a hit, zero otherwise |
| rsp_par_err_o | output | 1 | Matching entry failed a parity check |

## Verification
The embedded properties check several rules on every clock. Each request yields exactly one response one cycle later. A miss or a parity failure never carries an address, and the two flags are never high together. A fill into a set with a free way raises that set's occupancy by exactly one. A flush leaves every way empty. Which way the pseudo-LRU tree evicts, how lookup hits steer later evictions, whether a same-cycle lookup sees pre-update contents, and the exact physical addresses returned can only be shown by the bench. It fills sets to overflow and then probes which tags survive.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // Victim chosen by a 3-bit tree: bit 0 picks the pair, bits 1/2 pick within it
   function automatic logic [1:0] plru_pick(input logic [2:0] tree);
      if (!tree[0]) return tree[1] ? 2'd1 : 2'd0;
      else          return tree[2] ? 2'd3 : 2'd2;
   endfunction

   // Steer the tree away from the way just used
   function automatic logic [2:0] plru_touch(input logic [2:0] tree,
                                             input logic [1:0] way);
      logic [2:0] nxt;
      nxt    = tree;
      nxt[0] = ~way[1];
      if (!way[1]) nxt[1] = ~way[0];
      else         nxt[2] = ~way[0];
      return nxt;
   endfunction

endpackage

// File: rtl/xlat_way.sv
module xlat_way #(
   parameter int SETS      = 16,
   parameter int TAG_W     = 16,
   parameter int PFN_W     = 20,
   parameter bit PARITY_EN = 1'b1,
   localparam int IDX_W    = $clog2(SETS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic             wr_tpar_i,
   input  logic [PFN_W-1:0] wr_pfn_i,
   input  logic             wr_ppar_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_vld_o,
   output logic [TAG_W-1:0] rd_tag_o,
   output logic [PFN_W-1:0] rd_pfn_o,
   output logic             rd_par_ok_o,
   output logic [SETS-1:0]  vld_vec_o
);

   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PFN_W-1:0] pfn_q [SETS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q <= '0;
      end else if (flush_i) begin
         vld_q <= '0;
      end else if (wr_en_i) begin
         vld_q[wr_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (wr_en_i && !flush_i) begin
         tag_q[wr_idx_i] <= wr_tag_i;
         pfn_q[wr_idx_i] <= wr_pfn_i;
      end
   end

   assign rd_vld_o  = vld_q[rd_idx_i];
   assign rd_tag_o  = tag_q[rd_idx_i];
   assign rd_pfn_o  = pfn_q[rd_idx_i];
   assign vld_vec_o = vld_q;

   generate
      if (PARITY_EN) begin : g_par
         logic tpar_q [SETS];
         logic ppar_q [SETS];
         always_ff @(posedge clk_i) begin
            if (wr_en_i && !flush_i) begin
               tpar_q[wr_idx_i] <= wr_tpar_i;
               ppar_q[wr_idx_i] <= wr_ppar_i;
            end
         end
         assign rd_par_ok_o = ((^rd_tag_o) == tpar_q[rd_idx_i]) &&
                              ((^rd_pfn_o) == ppar_q[rd_idx_i]);
      end else begin : g_nopar
         logic unused_par;
         assign unused_par  = wr_tpar_i ^ wr_ppar_i;
         assign rd_par_ok_o = 1'b1;
      end
   endgenerate

   // R8
   flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (vld_q == '0));

endmodule

// File: rtl/xlat_plru.sv
module xlat_plru
   import xlat_pkg::*;
#(
   parameter int SETS  = 16,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             lkp_en_i,
   input  logic [IDX_W-1:0] lkp_idx_i,
   input  logic [1:0]       lkp_way_i,
   input  logic             fill_en_i,
   input  logic [IDX_W-1:0] fill_idx_i,
   input  logic [1:0]       fill_way_i,
   output logic [2:0]       fill_tree_o
);

   logic [2:0] tree_q [SETS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (flush_i) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else begin
         if (lkp_en_i && !(fill_en_i && (fill_idx_i == lkp_idx_i)))
            tree_q[lkp_idx_i] <= plru_touch(tree_q[lkp_idx_i], lkp_way_i);
         if (fill_en_i)
            tree_q[fill_idx_i] <= plru_touch(tree_q[fill_idx_i], fill_way_i);
      end
   end

   assign fill_tree_o = tree_q[fill_idx_i];

endmodule

// File: rtl/xlat_top.sv
module xlat_top
   import xlat_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_W    = 12,
   parameter int ENTRIES   = 64,
   parameter int WAYS      = 4,
   parameter int PFN_W     = 20,
   parameter bit PARITY_EN = 1'b1,
   localparam int SETS     = ENTRIES / WAYS,
   localparam int IDX_W    = $clog2(SETS),
   localparam int TAG_W    = VA_W - PAGE_W - IDX_W,
   localparam int PA_W     = PFN_W + PAGE_W,
   localparam int WAY_W    = $clog2(WAYS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lkp_vld_i,
   input  logic [VA_W-1:0]  lkp_va_i,
   input  logic             fill_vld_i,
   input  logic [VA_W-1:0]  fill_va_i,
   input  logic [PFN_W-1:0] fill_pfn_i,
   input  logic             fill_tag_par_i,
   input  logic             fill_pfn_par_i,
   input  logic             flush_i,
   output logic             rsp_vld_o,
   output logic             rsp_hit_o,
   output logic [PA_W-1:0]  rsp_pa_o,
   output logic             rsp_par_err_o
);

   generate
      if (WAYS != 4) begin : g_bad_ways
         $error("xlat_top: the 3-bit tree replacement needs WAYS == 4");
      end
      if ((SETS < 2) || ((1 << IDX_W) != SETS) || (SETS * WAYS != ENTRIES)) begin : g_bad_sets
         $error("xlat_top: ENTRIES/WAYS must be a power of two >= 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("xlat_top: address too narrow for page offset and index");
      end
   endgenerate

   // ---------------- address split ----------------
   logic [IDX_W-1:0] lkp_idx, fill_idx;
   logic [TAG_W-1:0] lkp_tag, fill_tag;

   assign lkp_idx  = lkp_va_i[PAGE_W +: IDX_W];
   assign lkp_tag  = lkp_va_i[VA_W-1 -: TAG_W];
   assign fill_idx = fill_va_i[PAGE_W +: IDX_W];
   assign fill_tag = fill_va_i[VA_W-1 -: TAG_W];

   // ---------------- way storage ----------------
   logic [WAYS-1:0]  way_wr;
   logic [WAYS-1:0]  rd_vld, rd_ok;
   logic [TAG_W-1:0] rd_tag [WAYS];
   logic [PFN_W-1:0] rd_pfn [WAYS];
   logic [SETS-1:0]  vld_vec [WAYS];

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         xlat_way #(
            .SETS      (SETS),
            .TAG_W     (TAG_W),
            .PFN_W     (PFN_W),
            .PARITY_EN (PARITY_EN)
         ) way_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .flush_i     (flush_i),
            .wr_en_i     (way_wr[w]),
            .wr_idx_i    (fill_idx),
            .wr_tag_i    (fill_tag),
            .wr_tpar_i   (fill_tag_par_i),
            .wr_pfn_i    (fill_pfn_i),
            .wr_ppar_i   (fill_pfn_par_i),
            .rd_idx_i    (lkp_idx),
            .rd_vld_o    (rd_vld[w]),
            .rd_tag_o    (rd_tag[w]),
            .rd_pfn_o    (rd_pfn[w]),
            .rd_par_ok_o (rd_ok[w]),
            .vld_vec_o   (vld_vec[w])
         );
      end
   endgenerate

   // ---------------- lookup compare ----------------
   logic [WAYS-1:0]  tag_eq, good_vec, bad_vec;
   logic             lkp_hit, lkp_bad;
   logic [WAY_W-1:0] hit_way;
   logic [PFN_W-1:0] hit_pfn;

   always_comb begin
      hit_way = '0;
      hit_pfn = '0;
      for (int w = 0; w < WAYS; w++) begin
         tag_eq[w]   = rd_vld[w] && (rd_tag[w] == lkp_tag);
         good_vec[w] = tag_eq[w] && rd_ok[w];
         bad_vec[w]  = tag_eq[w] && !rd_ok[w];
         if (good_vec[w]) hit_pfn = hit_pfn | rd_pfn[w];
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (good_vec[w]) hit_way = WAY_W'(w);
      end
      lkp_bad = |bad_vec;
      lkp_hit = (|good_vec) && !lkp_bad;
   end

   // ---------------- victim choice ----------------
   logic [WAYS-1:0]  free_row;
   logic [WAY_W-1:0] free_way, victim;
   logic [2:0]       fill_tree;
   logic             fill_go;

   always_comb begin
      free_way = '0;
      for (int w = 0; w < WAYS; w++) free_row[w] = !vld_vec[w][fill_idx];
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (free_row[w]) free_way = WAY_W'(w);
      end
      victim  = (|free_row) ? free_way : plru_pick(fill_tree);
      fill_go = fill_vld_i && !flush_i;
      for (int w = 0; w < WAYS; w++) way_wr[w] = fill_go && (victim == WAY_W'(w));
   end

   xlat_plru #(
      .SETS (SETS)
   ) plru_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush_i),
      .lkp_en_i    (lkp_vld_i && lkp_hit),
      .lkp_idx_i   (lkp_idx),
      .lkp_way_i   (hit_way),
      .fill_en_i   (fill_go),
      .fill_idx_i  (fill_idx),
      .fill_way_i  (victim),
      .fill_tree_o (fill_tree)
   );

   // ---------------- response register ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_vld_o     <= 1'b0;
         rsp_hit_o     <= 1'b0;
         rsp_pa_o      <= '0;
         rsp_par_err_o <= 1'b0;
      end else begin
         rsp_vld_o     <= lkp_vld_i;
         rsp_hit_o     <= lkp_vld_i && lkp_hit;
         rsp_pa_o      <= (lkp_vld_i && lkp_hit) ? {hit_pfn, lkp_va_i[PAGE_W-1:0]} : '0;
         rsp_par_err_o <= lkp_vld_i && lkp_bad;
      end
   end

   // R1
   one_rsp_per_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lkp_vld_i |=> rsp_vld_o);

   // R1
   no_rsp_unasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lkp_vld_i |=> !rsp_vld_o);

   // R3
   miss_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rsp_hit_o |-> (rsp_pa_o == '0));

   // R7
   par_err_is_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_par_err_o |-> (rsp_vld_o && !rsp_hit_o));

   // R4: occupancy of a set with a free way grows by exactly one per fill
   logic             occ_fill_q;
   logic [IDX_W-1:0] occ_idx_q;
   logic [WAY_W:0]   occ_cnt_q;
   logic [WAYS-1:0]  occ_row;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         occ_fill_q <= 1'b0;
         occ_idx_q  <= '0;
         occ_cnt_q  <= '0;
      end else begin
         occ_fill_q <= fill_go && (|free_row);
         occ_idx_q  <= fill_idx;
         occ_cnt_q  <= (WAY_W+1)'($countones(~free_row));
      end
   end

   always_comb begin
      for (int w = 0; w < WAYS; w++) occ_row[w] = vld_vec[w][occ_idx_q];
   end

   // R4
   fill_adds_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_fill_q |-> ($countones(occ_row) == int'(occ_cnt_q) + 1));

endmodule

// File: tb/xlat_top_tb_top.sv
module xlat_top_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lkp_vld, fill_vld, fill_tpar, fill_ppar, flush;
   logic [31:0] lkp_va, fill_va;
   logic [19:0] fill_pfn;
   logic        rsp_vld, rsp_hit, rsp_perr;
   logic [31:0] rsp_pa;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xlat_top dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .lkp_vld_i      (lkp_vld),
      .lkp_va_i       (lkp_va),
      .fill_vld_i     (fill_vld),
      .fill_va_i      (fill_va),
      .fill_pfn_i     (fill_pfn),
      .fill_tag_par_i (fill_tpar),
      .fill_pfn_par_i (fill_ppar),
      .flush_i        (flush),
      .rsp_vld_o      (rsp_vld),
      .rsp_hit_o      (rsp_hit),
      .rsp_pa_o       (rsp_pa),
      .rsp_par_err_o  (rsp_perr)
   );

   typedef struct {
      logic        hit;
      logic [31:0] pa;
      logic        perr;
      string       req;
   } exp_t;

   exp_t sb_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;

   task automatic compare(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_va(input logic [15:0] tg, input logic [3:0] ix,
                                         input logic [11:0] off);
      return {tg, ix, off};
   endfunction

   // ---------------- driver ----------------
   task automatic set_fill(input logic [15:0] tg, input logic [3:0] ix, input logic [19:0] pfn,
                           input logic tbad, input logic pbad);
      fill_vld  = 1'b1;
      fill_va   = mk_va(tg, ix, 12'h000);
      fill_pfn  = pfn;
      fill_tpar = (^tg) ^ tbad;
      fill_ppar = (^pfn) ^ pbad;
   endtask

   task automatic set_lkp(input logic [15:0] tg, input logic [3:0] ix, input logic [11:0] off,
                          input logic ehit, input logic [19:0] epfn, input logic eperr,
                          input string req);
      exp_t e;
      lkp_vld = 1'b1;
      lkp_va  = mk_va(tg, ix, off);
      e.hit   = ehit;
      e.pa    = ehit ? {epfn, off} : 32'h0;
      e.perr  = eperr;
      e.req   = req;
      sb_q.push_back(e);
   endtask

   task automatic step();
      @(negedge clk);
      lkp_vld  = 1'b0;
      fill_vld = 1'b0;
      flush    = 1'b0;
   endtask

   task automatic fill(input logic [15:0] tg, input logic [3:0] ix, input logic [19:0] pfn);
      set_fill(tg, ix, pfn, 1'b0, 1'b0);
      step();
   endtask

   task automatic look(input logic [15:0] tg, input logic [3:0] ix, input logic [11:0] off,
                       input logic ehit, input logic [19:0] epfn, input string req);
      set_lkp(tg, ix, off, ehit, epfn, 1'b0, req);
      step();
   endtask

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rsp_vld === 1'b1) begin
         if (sb_q.size() == 0) begin
            compare("R1", "unexpected response", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.req, "hit", 64'(rsp_hit), 64'(e.hit));
            compare(e.req, "pa", 64'(rsp_pa), 64'(e.pa));
            compare(e.req, "parity error", 64'(rsp_perr), 64'(e.perr));
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      rst_n = 1'b0; lkp_vld = 1'b0; fill_vld = 1'b0; flush = 1'b0;
      lkp_va = '0; fill_va = '0; fill_pfn = '0; fill_tpar = 1'b0; fill_ppar = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: outputs idle after reset
      compare("R10", "rsp_vld", 64'(rsp_vld), 64'd0);
      compare("R10", "hit/perr/pa", {rsp_hit, rsp_perr, rsp_pa}, 64'd0);

      // R10 / R3: empty buffer misses
      look(16'h0042, 4'd3, 12'h010, 1'b0, 20'h0, "R10");

      // R1 / R2 / R3: basic install and address split
      fill(16'h1234, 4'd5, 20'hABCDE);
      look(16'h1234, 4'd5, 12'h7F0, 1'b1, 20'hABCDE, "R1");
      look(16'h1234, 4'd5, 12'hFFF, 1'b1, 20'hABCDE, "R1");
      look(16'h1234, 4'd6, 12'h7F0, 1'b0, 20'h0, "R2");
      look(16'h1235, 4'd5, 12'h7F0, 1'b0, 20'h0, "R3");

      // R4 / R5 / R6: fills A..D, hit on A, overflow evicts way 2 (C)
      fill(16'h00A0, 4'd2, 20'h10000);
      fill(16'h00A1, 4'd2, 20'h10001);
      fill(16'h00A2, 4'd2, 20'h10002);
      fill(16'h00A3, 4'd2, 20'h10003);
      look(16'h00A0, 4'd2, 12'h004, 1'b1, 20'h10000, "R6");
      fill(16'h00A4, 4'd2, 20'h10004);
      look(16'h00A2, 4'd2, 12'h008, 1'b0, 20'h0, "R6");
      look(16'h00A0, 4'd2, 12'h00C, 1'b1, 20'h10000, "R4");
      look(16'h00A1, 4'd2, 12'h00C, 1'b1, 20'h10001, "R4");
      look(16'h00A3, 4'd2, 12'h00C, 1'b1, 20'h10003, "R4");
      look(16'h00A4, 4'd2, 12'h00C, 1'b1, 20'h10004, "R5");

      // R5: four fills then a fifth with no hits evicts way 0
      fill(16'h00B0, 4'd4, 20'h20000);
      fill(16'h00B1, 4'd4, 20'h20001);
      fill(16'h00B2, 4'd4, 20'h20002);
      fill(16'h00B3, 4'd4, 20'h20003);
      fill(16'h00B4, 4'd4, 20'h20004);
      look(16'h00B0, 4'd4, 12'h100, 1'b0, 20'h0, "R5");
      look(16'h00B1, 4'd4, 12'h100, 1'b1, 20'h20001, "R5");
      look(16'h00B4, 4'd4, 12'h100, 1'b1, 20'h20004, "R5");

      // R6: hit on way 2, then two overflows evict way 0 then way 3
      fill(16'h00C0, 4'd8, 20'h30000);
      fill(16'h00C1, 4'd8, 20'h30001);
      fill(16'h00C2, 4'd8, 20'h30002);
      fill(16'h00C3, 4'd8, 20'h30003);
      look(16'h00C2, 4'd8, 12'h020, 1'b1, 20'h30002, "R6");
      fill(16'h00C4, 4'd8, 20'h30004);
      fill(16'h00C5, 4'd8, 20'h30005);
      look(16'h00C0, 4'd8, 12'h020, 1'b0, 20'h0, "R6");
      look(16'h00C3, 4'd8, 12'h020, 1'b0, 20'h0, "R6");
      look(16'h00C1, 4'd8, 12'h020, 1'b1, 20'h30001, "R6");
      look(16'h00C2, 4'd8, 12'h020, 1'b1, 20'h30002, "R6");
      look(16'h00C5, 4'd8, 12'h020, 1'b1, 20'h30005, "R6");

      // R7: corrupted tag parity and corrupted frame parity
      set_fill(16'h0D00, 4'd9, 20'h40000, 1'b1, 1'b0);
      step();
      set_lkp(16'h0D00, 4'd9, 12'h040, 1'b0, 20'h0, 1'b1, "R7");
      step();
      set_fill(16'h0E00, 4'd10, 20'h50001, 1'b0, 1'b1);
      step();
      set_lkp(16'h0E00, 4'd10, 12'h040, 1'b0, 20'h0, 1'b1, "R7");
      step();
      fill(16'h0E01, 4'd10, 20'h50002);
      look(16'h0E01, 4'd10, 12'h044, 1'b1, 20'h50002, "R7");

      // R9: lookup in the same cycle as the fill sees the old contents
      set_fill(16'h0077, 4'd11, 20'h60000, 1'b0, 1'b0);
      set_lkp(16'h0077, 4'd11, 12'h0AA, 1'b0, 20'h0, 1'b0, "R9");
      step();
      look(16'h0077, 4'd11, 12'h0AA, 1'b1, 20'h60000, "R9");

      // R9 / R8: lookup alongside flush still hits, afterwards everything misses
      flush = 1'b1;
      set_lkp(16'h1234, 4'd5, 12'h123, 1'b1, 20'hABCDE, 1'b0, "R9");
      step();
      look(16'h1234, 4'd5, 12'h123, 1'b0, 20'h0, "R8");
      look(16'h00A4, 4'd2, 12'h123, 1'b0, 20'h0, "R8");
      look(16'h0077, 4'd11, 12'h123, 1'b0, 20'h0, "R8");

      // R8: fill in the flush cycle is discarded
      flush = 1'b1;
      set_fill(16'h0F0F, 4'd12, 20'h70000, 1'b0, 1'b0);
      step();
      look(16'h0F0F, 4'd12, 12'h000, 1'b0, 20'h0, "R8");

      repeat (3) step();
      compare("R1", "responses outstanding", 64'(sb_q.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule